// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-bit Words

This block is a slave on a two-wire serial bus (I2C-compatible, standard framing), clocked by a fast system clock that oversamples the bus lines. Both lines pass through multi-flop synchronizers. Edge logic on the synchronized lines finds bus events. A bit framer counts the nine clock cycles of each byte. A controller then walks through each transfer. A transfer starts with a device-address byte. A write goes on with one pointer byte and then data. A read returns data at once from the last pointer that was set.

Register contents are 16 bits wide and cross the bus as two bytes, upper byte first. The block reaches the registers through a plain register-file port: a pointer, write data, a one-cycle write strobe and combinational read data. It drives the data line only through an open-drain enable, so a high `sda_oe` pulls the line low. It never stretches the clock.

Top module: `i2c_word_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) or a repeated START begins address matching from any state, including partway through a byte, without first passing through idle.
- R2: A STOP (SDA rising while SCL is high) at any point, including partway through a byte, returns the controller to idle with `sda_oe` low. After reset, `sda_oe` and `reg_we` are low.
- R3: The first byte after a START carries the device address in bits 7:1 and the direction in bit 0. On a match with `DEV_ADDR` the slave acknowledges by driving SDA low in the ninth clock. On a mismatch it does not acknowledge, and it neither drives SDA nor writes until the next START or STOP.
- R4: Bytes are eight data bits, MSB first, then one acknowledge bit. Incoming SDA is sampled at SCL rising edges. `sda_oe` changes only while the synchronized SCL is low, except at a START or STOP.
- R5: In a write (direction bit 0), the byte after the address is a pointer byte that loads `reg_addr`. The slave acknowledges the pointer byte and every data byte.
- R6: A write stores a 16-bit word (first data byte in bits 15:8) with a single one-cycle `reg_we` pulse. The pulse comes only after both bytes have been received and acknowledged. If a STOP or START cuts a word off after its first byte, nothing is written.
- R7: The pointer advances by one, modulo 2^AW, after each complete word, whether written or read. After the last byte of a read word it advances even when the master does not acknowledge that byte.
- R8: A read (direction bit 1) returns the word at the current pointer, upper byte first, and continues with the following words for as long as the master acknowledges.
- R9: If the master does not acknowledge a read byte (SDA high in the ninth clock), the slave stops driving and ignores the bus until the next START or STOP. A refusal after the upper byte drops the rest of the word and leaves the pointer unchanged.
- R10: A repeated START between a write of the pointer and a read keeps the pointer, so the read returns the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_addr | output | AW | Register pointer |
| reg_wdata | output | 16 | Word to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word at `reg_addr`, combinational |

## Verification
The hardest case to reach from the pins is a read in which the master refuses the upper byte. The slave must go quiet with half a word sent, and its pointer must stay where it was. The bench reaches this case by selecting a register through a write, switching to a read with a repeated START, and answering the first data byte with a NACK. It then clocks another byte that must come back as all ones. A fresh read follows, which must return the same register. Transactions cut off by a STOP or a START partway through an address byte, or after half a data word, are driven the same way. Each is followed by a normal transaction that has to succeed.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_IGNORE
    } ctl_state_e;

    localparam int          BYTE_BITS = 8;
    localparam logic [3:0]  CNT_ACK   = 4'd8;   // eight data bits seen, ack slot next
    localparam logic [3:0]  CNT_POST  = 4'd9;   // ack bit sampled, waiting for its falling edge

    // Events derived from the synchronized bus lines
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Events derived from the bit count
    typedef struct packed {
        logic       data_end;   // SCL falls after the eighth data bit
        logic       ack_rise;   // SCL rises in the acknowledge slot
        logic       ack_end;    // SCL falls at the end of the acknowledge slot
        logic       bit_fall;   // SCL falls inside a byte, before bit index bit_idx
        logic [2:0] bit_idx;
        logic [7:0] rx_byte;
    } frame_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

    // Transmit bit k (0 = MSB) of the upper or lower byte of a word
    function automatic logic pick_bit(input logic [15:0] w, input logic lo, input logic [2:0] k);
        logic [3:0] pos;
        pos = {~lo, ~k};
        return w[pos];
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync
    import i2cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s = scl_pipe[LAST];
    assign sda_s = sda_pipe[LAST];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2cw_framer.sv
module i2cw_framer
    import i2cw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      sda_s,
    input  logic      start,
    input  logic      stop,
    output frame_ev_t fev
);

    // cnt counts rising edges within a byte, so the falling edge that
    // follows a START finds cnt = 0 and is not taken as a bit.
    logic [3:0] cnt;
    logic [7:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (start || stop) begin
            cnt   <= '0;
        end else if (scl_rise) begin
            if (cnt < CNT_ACK) begin
                shreg <= {shreg[BYTE_BITS-2:0], sda_s};
                cnt   <= cnt + 4'd1;
            end else if (cnt == CNT_ACK) begin
                cnt   <= CNT_POST;
            end
        end else if (scl_fall && cnt == CNT_POST) begin
            cnt <= '0;
        end
    end

    always_comb begin
        fev.data_end = scl_fall && (cnt == CNT_ACK);
        fev.ack_rise = scl_rise && (cnt == CNT_ACK);
        fev.ack_end  = scl_fall && (cnt == CNT_POST);
        fev.bit_fall = scl_fall && (cnt != 4'd0) && (cnt < CNT_ACK);
        fev.bit_idx  = cnt[2:0];
        fev.rx_byte  = shreg;
    end

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         AW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          sda_s,
    input  frame_ev_t     fev,
    input  logic [15:0]   reg_rdata,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [15:0]   reg_wdata,
    output logic          reg_we,
    output ctl_state_e    state_o
);

    ctl_state_e    state;
    logic [AW-1:0] ptr;
    logic [7:0]    hi_byte;
    logic [15:0]   tx_word;
    logic          half;     // 0: upper byte of the word, 1: lower byte
    logic          rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            hi_byte   <= '0;
            tx_word   <= '0;
            half      <= 1'b0;
            rw        <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            // pointer steps one cycle after a write strobe
            if (reg_we) begin
                ptr <= ptr + 1'b1;
            end
            if (stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
                half   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (fev.data_end) begin
                            if (addr_hit(fev.rx_byte, DEV_ADDR)) begin
                                sda_oe <= 1'b1;
                                rw     <= fev.rx_byte[0];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IGNORE;
                            end
                        end else if (fev.ack_end) begin
                            half <= 1'b0;
                            if (rw) begin
                                state   <= ST_RD;
                                tx_word <= reg_rdata;
                                sda_oe  <= ~reg_rdata[15];
                            end else begin
                                state   <= ST_CMD;
                                sda_oe  <= 1'b0;
                            end
                        end
                    end
                    ST_CMD: begin
                        if (fev.data_end) begin
                            sda_oe <= 1'b1;
                        end else if (fev.ack_end) begin
                            sda_oe <= 1'b0;
                            ptr    <= fev.rx_byte[AW-1:0];
                            half   <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_WR: begin
                        if (fev.data_end) begin
                            sda_oe <= 1'b1;
                        end else if (fev.ack_end) begin
                            sda_oe <= 1'b0;
                            if (!half) begin
                                hi_byte <= fev.rx_byte;
                                half    <= 1'b1;
                            end else begin
                                reg_wdata <= {hi_byte, fev.rx_byte};
                                reg_we    <= 1'b1;
                                half      <= 1'b0;
                            end
                        end
                    end
                    ST_RD: begin
                        if (fev.data_end) begin
                            sda_oe <= 1'b0;
                        end else if (fev.ack_rise) begin
                            if (half) begin
                                ptr <= ptr + 1'b1;
                            end
                            if (sda_s) begin
                                state <= ST_IGNORE;
                            end
                        end else if (fev.ack_end) begin
                            if (!half) begin
                                half   <= 1'b1;
                                sda_oe <= ~tx_word[7];
                            end else begin
                                half    <= 1'b0;
                                tx_word <= reg_rdata;
                                sda_oe  <= ~reg_rdata[15];
                            end
                        end else if (fev.bit_fall) begin
                            sda_oe <= ~pick_bit(tx_word, half, fev.bit_idx);
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign reg_addr = ptr;
    assign state_o  = state;

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [15:0]   reg_wdata,
    output logic          reg_we,
    input  logic [15:0]   reg_rdata
);

    bus_ev_t    bus_ev;
    frame_ev_t  fev;
    ctl_state_e ctl_state;
    logic       scl_s;
    logic       start_ev;
    logic       stop_ev;

    assign scl_s    = bus_ev.scl;
    assign start_ev = bus_ev.start;
    assign stop_ev  = bus_ev.stop;

    i2cw_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    i2cw_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .scl_rise (bus_ev.scl_rise),
        .scl_fall (bus_ev.scl_fall),
        .sda_s    (bus_ev.sda),
        .start    (start_ev),
        .stop     (stop_ev),
        .fev      (fev)
    );

    i2cw_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .AW       (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start_ev),
        .stop      (stop_ev),
        .sda_s     (bus_ev.sda),
        .fev       (fev),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .state_o   (ctl_state)
    );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
    import i2cw_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_s,
    input logic          start_ev,
    input logic          stop_ev,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input ctl_state_e    state
);

    assert_start_addr_R1: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (state == ST_ADDR));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    assert_oe_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        (scl_s && !start_ev && !stop_ev) |=> $stable(sda_oe));

    assert_we_single_R6: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_we_in_write_R6: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (state == ST_WR));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));

endmodule

bind i2c_word_slave i2cw_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .state    (ctl_state)
);

// File: tb/i2c_word_slave_tb.sv
module i2c_word_slave_tb;

    localparam logic [6:0] DEV = 7'h2C;
    localparam int         AW  = 8;
    localparam int         Q   = 5;      // quarter SCL period in clk cycles
    localparam int         NREG = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic          reg_we;
    logic [AW-1:0] reg_addr;
    logic [15:0]   reg_wdata;
    logic [15:0]   reg_rdata;
    wire           sda_line = sda_m & ~sda_oe;

    logic [15:0] regs     [NREG];
    logic [15:0] exp_regs [NREG];
    int          we_count = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [AW-1:0] exp_ptr = '0;

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
    end

    i2c_word_slave #(.DEV_ADDR(DEV), .AW(AW), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = ~give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_word(input logic ack_last, output logic [15:0] w);
        logic [7:0] h, l;
        rd_byte(1'b1, h);
        rd_byte(ack_last, l);
        w = {h, l};
        exp_ptr = exp_ptr + 1'b1;
    endtask

    function automatic logic [15:0] seed_val(input int i);
        return 16'(i * 16'h0107) ^ 16'h5A3C;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        summary();
    end

    initial begin
        logic        ack;
        logic [7:0]  b;
        logic [15:0] w;
        int          we0;

        for (int i = 0; i < NREG; i++) begin
            regs[i]     = seed_val(i);
            exp_regs[i] = seed_val(i);
        end
        tick(4);
        chk("R2 reset oe", {31'd0, sda_oe}, 0);
        chk("R2 reset we", {31'd0, reg_we}, 0);
        rst = 1'b0;
        tick(4);

        // R3: sweep every device address
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wr_byte({7'(a), 1'b0}, ack);
            chk("R3 address ack", {31'd0, ack}, {31'd0, (7'(a) == DEV)});
            wr_byte(8'h00, ack);
            chk("R3 follow-on byte ack", {31'd0, ack}, {31'd0, (7'(a) == DEV)});
            if (7'(a) == DEV) exp_ptr = 8'h00;
            bus_stop();
        end
        chk("R3 no writes during sweep", we_count, 0);

        // R5 R6 R7: burst write of 12 words
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h10, ack);
        chk("R5 pointer byte ack", {31'd0, ack}, 1);
        exp_ptr = 8'h10;
        for (int i = 0; i < 12; i++) begin
            w = 16'(i * 16'h1357) ^ 16'hA5C3;
            wr_byte(w[15:8], ack);
            chk("R5 upper data ack", {31'd0, ack}, 1);
            wr_byte(w[7:0], ack);
            chk("R5 lower data ack", {31'd0, ack}, 1);
            exp_regs[8'h10 + i] = w;
            exp_ptr = exp_ptr + 1'b1;
        end
        bus_stop();
        chk("R6 write count", we_count, 12);
        for (int i = 0; i < 12; i++)
            chk("R6 stored word", regs[8'h10 + i], exp_regs[8'h10 + i]);
        chk("R7 pointer after burst", reg_addr, exp_ptr);

        // R8 R10: read back through a repeated START
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h10, ack);
        exp_ptr = 8'h10;
        bus_rstart();
        wr_byte({DEV, 1'b1}, ack);
        chk("R3 read address ack", {31'd0, ack}, 1);
        for (int i = 0; i < 12; i++) begin
            rd_word(i != 11, w);
            chk("R8 R10 read word", w, exp_regs[8'h10 + i]);
        end
        bus_stop();
        chk("R7 pointer after read", reg_addr, exp_ptr);

        // R6: half word cut off by STOP
        we0 = we_count;
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h50, ack);
        wr_byte(8'hDE, ack);
        bus_stop();
        exp_ptr = 8'h50;
        chk("R6 half word no strobe", we_count, we0);
        chk("R6 half word untouched", regs[8'h50], exp_regs[8'h50]);

        // R6 R10: half word cut off by repeated START, then read
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h51, ack);
        wr_byte(8'hBE, ack);
        exp_ptr = 8'h51;
        bus_rstart();
        wr_byte({DEV, 1'b1}, ack);
        rd_word(1'b0, w);
        bus_stop();
        chk("R6 R10 dropped word", w, exp_regs[8'h51]);
        chk("R6 no strobe on restart", we_count, we0);

        // R9: refuse upper byte of a read
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h60, ack);
        exp_ptr = 8'h60;
        bus_rstart();
        wr_byte({DEV, 1'b1}, ack);
        rd_byte(1'b0, b);
        chk("R9 upper byte", b, exp_regs[8'h60][15:8]);
        chk("R9 released after nack", {31'd0, sda_oe}, 0);
        rd_byte(1'b0, b);
        chk("R9 bus ignored after nack", b, 8'hFF);
        bus_stop();
        chk("R9 pointer unchanged", reg_addr, exp_ptr);
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        rd_word(1'b0, w);
        bus_stop();
        chk("R9 same word again", w, exp_regs[8'h60]);
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        rd_word(1'b0, w);
        bus_stop();
        chk("R7 advance after nacked lower byte", w, exp_regs[8'h61]);

        // R7: wrap at the top of the register space
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'hFF, ack);
        exp_ptr = 8'hFF;
        for (int i = 0; i < 2; i++) begin
            w = 16'hC001 + 16'(i * 16'h1111);
            wr_byte(w[15:8], ack);
            wr_byte(w[7:0], ack);
            exp_regs[exp_ptr] = w;
            exp_ptr = exp_ptr + 1'b1;
        end
        bus_stop();
        chk("R7 wrap word FF", regs[8'hFF], exp_regs[8'hFF]);
        chk("R7 wrap word 00", regs[8'h00], exp_regs[8'h00]);
        chk("R7 wrap pointer", reg_addr, 8'h01);

        // R2: STOP partway through an address byte
        bus_start();
        send_bits({DEV, 1'b0}, 4);
        bus_stop();
        chk("R2 released after mid-byte stop", {31'd0, sda_oe}, 0);

        // R1: START partway through a byte, then read
        bus_start();
        send_bits({DEV, 1'b1}, 3);
        bus_rstart();
        wr_byte({DEV, 1'b1}, ack);
        chk("R1 R2 address after restart", {31'd0, ack}, 1);
        rd_word(1'b0, w);
        bus_stop();
        chk("R1 read after restart", w, exp_regs[8'h01]);

        // R4: walking one through every bit position
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h80, ack);
        exp_ptr = 8'h80;
        for (int i = 0; i < 16; i++) begin
            w = 16'(1) << i;
            wr_byte(w[15:8], ack);
            wr_byte(w[7:0], ack);
            exp_regs[8'h80 + i] = w;
        end
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h80, ack);
        bus_rstart();
        wr_byte({DEV, 1'b1}, ack);
        for (int i = 0; i < 16; i++) begin
            rd_word(i != 15, w);
            chk("R4 bit order", w, exp_regs[8'h80 + i]);
        end
        bus_stop();

        summary();
    end

endmodule